// File: doc/BRIEF.md
# Integer Execution Unit with Status Flags

This block is the integer execution stage of a processor datapath. Each cycle it may accept an operation code together with a destination operand and a source operand. It computes a result and updates a four-bit status register. The four flags are zero, sign, carry and overflow. The result and the flags are registered and appear on the outputs one clock after the operation is accepted. The stored flags are exported so that a branch unit outside the block can evaluate conditions on them.

A single adder serves addition, subtraction, increment, decrement and negation. The carry into its most significant bit and the carry out of it are both brought out. The carry flag (the unsigned view) and the overflow flag (the signed view) are derived from those two bits. A flag-write enable lets move and address-computation traffic use the unit without disturbing the flags. Some operations leave the flags alone by definition.

Top module: `alu_flags_unit`

## Requirements
- R1: The operation code is 4 bits wide. The codes are: 0 pass, 1 add, 2 subtract, 3 multiply, 4 increment, 5 decrement, 6 negate, 7 arithmetic left shift, 8 logical left shift, 9 arithmetic right shift, 10 logical right shift, 11 xor, 12 and, 13 or, 14 not. Code 15 behaves as pass. The results are, in code order from 1 to 14: dst+src, dst−src, the low W bits of the signed product dst×src, dst+1, dst−1, −dst, dst shifted left, dst shifted left, dst shifted right with sign fill, dst shifted right with zero fill, dst^src, dst&src, dst|src, and ~dst. All results are taken modulo 2^W. The result and the flags appear on the outputs on the clock edge that accepts the operation.
- R2: When an operation writes the flags, the zero flag is 1 exactly when the result is all zeros.
- R3: When an operation writes the flags, the sign flag equals the most significant bit of the result.
- R4: For add, the carry flag is the carry out of the most significant bit. For subtract and negate, the carry flag is the borrow: it is set when dst < src, or when the negated operand is non-zero. For add, subtract, increment, decrement and negate, the overflow flag is set when the carry into the most significant bit differs from the carry out of it.
- R5: Increment and decrement keep the previous carry flag.
- R6: For multiply, carry and overflow are both set exactly when the full signed product does not fit in W bits.
- R7: The shift count is src modulo W. Arithmetic and logical left shifts are identical. For a non-zero count, the carry flag is the last bit shifted out and the overflow flag is cleared.
- R8: A shift with a count of zero returns dst and changes no flag.
- R9: And, or and xor clear carry and overflow. Not changes no flag.
- R10: Pass returns src. Pass, and any operation issued with the flag-write enable low, leaves all four flags unchanged.
- R11: When no operation is accepted, the result and the flags hold their values.
- R12: After reset, the result and all four flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept an operation this cycle |
| op_i | input | 4 | Operation code (see R1) |
| dst_i | input | W | Destination operand |
| src_i | input | W | Source operand, also the shift count |
| flag_we_i | input | 1 | Allow the accepted operation to write the flags |
| result_o | output | W | Registered result |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |

## Verification
The hardest cases to reach are the ones whose outcome depends on flags left behind by earlier operations. Increment and decrement keep the old carry, and shifts by zero, not, pass and flag-masked operations must leave every flag as it was. Each of these only means something if the register already holds a mixed, non-trivial pattern. The bench therefore sweeps an 8-bit instance with every operation code, every destination value and a spread of sources, back to back. Flag-masked and idle cycles are interleaved, so each operation meets whatever flag state its predecessors produced. A 64-bit instance then receives the signed and unsigned boundary operands at full width.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_PASS = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_MUL  = 4'd3,
        OP_INC  = 4'd4,
        OP_DEC  = 4'd5,
        OP_NEG  = 4'd6,
        OP_SAL  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SAR  = 4'd9,
        OP_SHR  = 4'd10,
        OP_XOR  = 4'd11,
        OP_AND  = 4'd12,
        OP_OR   = 4'd13,
        OP_NOT  = 4'd14,
        OP_RSV  = 4'd15
    } op_t;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_ARITH = 2'd1,
        SH_LOGIC = 2'd2
    } sh_mode_t;

    typedef struct packed {
        logic zf;
        logic sf;
        logic cf;
        logic of;
    } flags_t;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         c_msb_in_o,
    output logic         c_out_o
);

    logic [W-1:0] low_d;

    always_comb begin
        // lower W-1 bits in one add; bit W-1 of low_d is the carry into the MSB
        low_d      = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
        c_msb_in_o = low_d[W-1];
        sum_o      = {a_i[W-1] ^ b_i[W-1] ^ low_d[W-1], low_d[W-2:0]};
        c_out_o    = (a_i[W-1] & b_i[W-1]) | (a_i[W-1] & low_d[W-1]) | (b_i[W-1] & low_d[W-1]);
        // R1, R4: split-carry adder equals a plain wide sum
        p_adder_sum_r4: assert ({c_out_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}));
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W  = 64,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  val_i,
    input  logic [CW-1:0] cnt_i,
    input  sh_mode_t      mode_i,
    output logic [W-1:0]  res_o,
    output logic          out_bit_o
);

    logic [W:0] left_d;
    logic [W:0] right_d;

    always_comb begin
        // one extra bit catches the last bit pushed out
        left_d  = {1'b0, val_i} << cnt_i;
        if (mode_i == SH_ARITH) begin
            right_d = $unsigned($signed({val_i, 1'b0}) >>> cnt_i);
        end else begin
            right_d = {val_i, 1'b0} >> cnt_i;
        end
        if (mode_i == SH_LEFT) begin
            res_o     = left_d[W-1:0];
            out_bit_o = left_d[W];
        end else begin
            res_o     = right_d[W:1];
            out_bit_o = right_d[0];
        end
    end

endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] lo_o,
    output logic         ovf_o
);

    logic signed [2*W-1:0] prod_d;
    logic [W:0]            upper_d;

    always_comb begin
        prod_d  = $signed(a_i) * $signed(b_i);
        lo_o    = prod_d[W-1:0];
        upper_d = prod_d[2*W-1:W-1];
        // fits when the upper half plus the low sign bit are all equal
        ovf_o   = !((&upper_d) || !(|upper_d));
    end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] src_i,
    input  logic         flag_we_i,
    output logic [W-1:0] result_o,
    output logic         zf_o,
    output logic         sf_o,
    output logic         cf_o,
    output logic         of_o
);

    localparam int CW = $clog2(W);

    typedef struct packed {
        logic [W-1:0] res;
        flags_t       fl;
    } state_t;

    state_t st_d, st_q;

    op_t          op;
    logic [W-1:0] add_a, add_b, add_sum;
    logic         add_cin, add_c_msb, add_cout;
    logic [W-1:0] sh_res, mul_lo;
    logic         sh_out, mul_ovf;
    sh_mode_t     sh_mode;
    logic [CW-1:0] sh_cnt;

    assign op     = op_t'(op_i);
    assign sh_cnt = src_i[CW-1:0];

    // operand steering for the shared adder
    always_comb begin
        add_a   = dst_i;
        add_b   = src_i;
        add_cin = 1'b0;
        unique case (op)
            OP_SUB: begin add_b = ~src_i; add_cin = 1'b1; end
            OP_INC: begin add_b = '0;     add_cin = 1'b1; end
            OP_DEC: begin add_b = '1;     add_cin = 1'b0; end
            OP_NEG: begin add_a = '0; add_b = ~dst_i; add_cin = 1'b1; end
            default: ;
        endcase
        unique case (op)
            OP_SAR:  sh_mode = SH_ARITH;
            OP_SHR:  sh_mode = SH_LOGIC;
            default: sh_mode = SH_LEFT;
        endcase
    end

    alu_adder #(.W(W)) u_adder (
        .a_i        (add_a),
        .b_i        (add_b),
        .cin_i      (add_cin),
        .sum_o      (add_sum),
        .c_msb_in_o (add_c_msb),
        .c_out_o    (add_cout)
    );

    alu_shifter #(.W(W), .CW(CW)) u_shifter (
        .val_i     (dst_i),
        .cnt_i     (sh_cnt),
        .mode_i    (sh_mode),
        .res_o     (sh_res),
        .out_bit_o (sh_out)
    );

    alu_mul #(.W(W)) u_mul (
        .a_i   (dst_i),
        .b_i   (src_i),
        .lo_o  (mul_lo),
        .ovf_o (mul_ovf)
    );

    always_comb begin
        logic [W-1:0] res_d;
        flags_t       fl_d;
        logic         upd_d;
        st_d  = st_q;
        fl_d  = st_q.fl;
        upd_d = 1'b1;
        res_d = src_i;
        unique case (op)
            OP_ADD: begin
                res_d   = add_sum;
                fl_d.cf = add_cout;
                fl_d.of = add_c_msb ^ add_cout;
            end
            OP_SUB, OP_NEG: begin
                res_d   = add_sum;
                fl_d.cf = ~add_cout;
                fl_d.of = add_c_msb ^ add_cout;
            end
            OP_INC, OP_DEC: begin
                res_d   = add_sum;
                fl_d.of = add_c_msb ^ add_cout;
            end
            OP_MUL: begin
                res_d   = mul_lo;
                fl_d.cf = mul_ovf;
                fl_d.of = mul_ovf;
            end
            OP_SAL, OP_SHL, OP_SAR, OP_SHR: begin
                res_d = sh_res;
                if (sh_cnt == '0) begin
                    upd_d = 1'b0;
                end else begin
                    fl_d.cf = sh_out;
                    fl_d.of = 1'b0;
                end
            end
            OP_XOR: begin res_d = dst_i ^ src_i; fl_d.cf = 1'b0; fl_d.of = 1'b0; end
            OP_AND: begin res_d = dst_i & src_i; fl_d.cf = 1'b0; fl_d.of = 1'b0; end
            OP_OR:  begin res_d = dst_i | src_i; fl_d.cf = 1'b0; fl_d.of = 1'b0; end
            OP_NOT: begin res_d = ~dst_i; upd_d = 1'b0; end
            default: begin res_d = src_i; upd_d = 1'b0; end
        endcase
        fl_d.zf = (res_d == '0);
        fl_d.sf = res_d[W-1];
        if (valid_i) begin
            st_d.res = res_d;
            if (flag_we_i && upd_d) begin
                st_d.fl = fl_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign zf_o     = st_q.fl.zf;
    assign sf_o     = st_q.fl.sf;
    assign cf_o     = st_q.fl.cf;
    assign of_o     = st_q.fl.of;

    // antecedent helpers for the checks below
    logic chk_zs_op, chk_logic_op, chk_incdec, chk_shift, chk_noflag;
    assign chk_zs_op    = valid_i && flag_we_i &&
                          (op inside {OP_ADD, OP_SUB, OP_MUL, OP_INC, OP_DEC, OP_NEG,
                                      OP_XOR, OP_AND, OP_OR});
    assign chk_logic_op = valid_i && flag_we_i && (op inside {OP_XOR, OP_AND, OP_OR});
    assign chk_incdec   = valid_i && (op inside {OP_INC, OP_DEC});
    assign chk_shift    = valid_i && (op inside {OP_SAL, OP_SHL, OP_SAR, OP_SHR}) && (sh_cnt == '0);
    assign chk_noflag   = valid_i && (!flag_we_i || op inside {OP_PASS, OP_NOT, OP_RSV});

    p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_zs_op |=> (zf_o == (result_o == '0)));

    p_sign_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_zs_op |=> (sf_o == result_o[W-1]));

    p_keep_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chk_incdec |=> $stable(cf_o));

    p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_shift |=> ($stable({zf_o, sf_o, cf_o, of_o}) && result_o == $past(dst_i)));

    p_logic_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_logic_op |=> (!cf_o && !of_o));

    p_flags_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chk_noflag |=> $stable({zf_o, sf_o, cf_o, of_o}));

    p_pass_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_PASS) |=> (result_o == $past(src_i)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(result_o) && $stable({zf_o, sf_o, cf_o, of_o})));

endmodule

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int WW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          n_valid = 1'b0, n_we = 1'b0;
    logic [3:0]    n_op = 4'd0;
    logic [NW-1:0] n_dst = '0, n_src = '0, n_res;
    logic          n_zf, n_sf, n_cf, n_of;

    logic          w_valid = 1'b0, w_we = 1'b0;
    logic [3:0]    w_op = 4'd0;
    logic [WW-1:0] w_dst = '0, w_src = '0, w_res;
    logic          w_zf, w_sf, w_cf, w_of;

    alu_flags_unit #(.W(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(n_valid), .op_i(n_op),
        .dst_i(n_dst), .src_i(n_src), .flag_we_i(n_we), .result_o(n_res),
        .zf_o(n_zf), .sf_o(n_sf), .cf_o(n_cf), .of_o(n_of)
    );

    alu_flags_unit #(.W(WW)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .valid_i(w_valid), .op_i(w_op),
        .dst_i(w_dst), .src_i(w_src), .flag_we_i(w_we), .result_o(w_res),
        .zf_o(w_zf), .sf_o(w_sf), .cf_o(w_cf), .of_o(w_of)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    function automatic logic bit_at(logic [127:0] x, int i);
        return x[i];
    endfunction

    // reference: returns {zf,sf,cf,of, result[63:0]}
    function automatic logic [67:0] model(int w, logic [3:0] op, logic [63:0] d,
                                          logic [63:0] s, logic we, logic [3:0] fl_in);
        logic [127:0] m, hb, dd, ss, full, r;
        logic signed [127:0] sd, ssg, prod, refit;
        logic z, sg, c, o, upd;
        int cnt;
        m   = (128'h1 << w) - 128'h1;
        hb  = 128'h1 << (w - 1);
        dd  = {64'b0, d} & m;
        ss  = {64'b0, s} & m;
        sd  = $signed((dd ^ hb) - hb);
        ssg = $signed((ss ^ hb) - hb);
        cnt = int'(ss[5:0]) & (w - 1);
        {z, sg, c, o} = fl_in;
        upd = 1'b1;
        r = ss;
        case (op)
            4'd1: begin
                full = dd + ss; r = full & m; c = bit_at(full, w);
                o = (bit_at(dd, w-1) == bit_at(ss, w-1)) && (bit_at(r, w-1) != bit_at(dd, w-1));
            end
            4'd2: begin
                full = dd - ss; r = full & m; c = (dd < ss);
                o = (bit_at(dd, w-1) != bit_at(ss, w-1)) && (bit_at(r, w-1) != bit_at(dd, w-1));
            end
            4'd3: begin
                prod  = sd * ssg;
                r     = prod & m;
                refit = $signed((r ^ hb) - hb);
                o = (refit != prod); c = o;
            end
            4'd4: begin r = (dd + 128'h1) & m; o = (dd == hb - 128'h1); end
            4'd5: begin r = (dd - 128'h1) & m; o = (dd == hb); end
            4'd6: begin r = (128'h0 - dd) & m; c = (dd != 0); o = (dd == hb); end
            4'd7, 4'd8: begin
                if (cnt == 0) begin r = dd; upd = 1'b0; end
                else begin full = dd << cnt; r = full & m; c = bit_at(full, w); o = 1'b0; end
            end
            4'd9: begin
                if (cnt == 0) begin r = dd; upd = 1'b0; end
                else begin r = $unsigned(sd >>> cnt) & m; c = bit_at(dd, cnt-1); o = 1'b0; end
            end
            4'd10: begin
                if (cnt == 0) begin r = dd; upd = 1'b0; end
                else begin r = dd >> cnt; c = bit_at(dd, cnt-1); o = 1'b0; end
            end
            4'd11: begin r = dd ^ ss; c = 1'b0; o = 1'b0; end
            4'd12: begin r = dd & ss; c = 1'b0; o = 1'b0; end
            4'd13: begin r = dd | ss; c = 1'b0; o = 1'b0; end
            4'd14: begin r = ~dd & m; upd = 1'b0; end
            default: begin r = ss; upd = 1'b0; end
        endcase
        if (upd && we) begin
            z  = (r == 0);
            sg = bit_at(r, w-1);
        end else begin
            {z, sg, c, o} = fl_in;
        end
        return {z, sg, c, o, r[63:0]};
    endfunction

    function automatic string tag_of(logic v, logic [3:0] op, logic we, logic [2:0] cnt);
        if (!v) return "R11";
        if (!we) return "R10";
        case (op)
            4'd1, 4'd2, 4'd6: return "R1 R4";
            4'd3: return "R1 R6";
            4'd4, 4'd5: return "R1 R4 R5";
            4'd7, 4'd8, 4'd9, 4'd10: return (cnt == 0) ? "R8" : "R7";
            4'd11, 4'd12, 4'd13, 4'd14: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [7:0] src_pick(int i);
        case (i)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h03;
            4: return 8'h04;  5: return 8'h05;  6: return 8'hfe;  7: return 8'h07;
            8: return 8'h08;  9: return 8'h7f;  10: return 8'h80; 11: return 8'h81;
            12: return 8'hff; 13: return 8'h55; 14: return 8'haa; default: return 8'h10;
        endcase
    endfunction

    logic [NW-1:0] exp_res8 = '0;
    logic [3:0]    exp_fl8 = 4'd0;
    string         tag8 = "R12";
    bit            pend8 = 1'b0;

    task automatic check8();
        checks++;
        if (n_res !== exp_res8 || {n_zf, n_sf, n_cf, n_of} !== exp_fl8) begin
            errors++;
            $display("FAIL %s (flags R2 R3): result=%h flags=%b expected result=%h flags=%b",
                     tag8, n_res, {n_zf, n_sf, n_cf, n_of}, exp_res8, exp_fl8);
        end
    endtask

    task automatic issue8(logic v, logic [3:0] op, logic [7:0] d, logic [7:0] s, logic we);
        logic [67:0] mo;
        @(negedge clk);
        if (pend8) check8();
        n_valid = v; n_op = op; n_dst = d; n_src = s; n_we = we;
        if (v) begin
            mo = model(NW, op, {56'b0, d}, {56'b0, s}, we, exp_fl8);
            exp_res8 = mo[7:0];
            exp_fl8  = mo[67:64];
        end
        tag8  = tag_of(v, op, we, s[2:0]);
        pend8 = 1'b1;
    endtask

    logic [WW-1:0] exp_resw = '0;
    logic [3:0]    exp_flw = 4'd0;

    task automatic wide(logic [3:0] op, logic [63:0] d, logic [63:0] s, logic we, string tag);
        logic [67:0] mo;
        @(negedge clk);
        w_valid = 1'b1; w_op = op; w_dst = d; w_src = s; w_we = we;
        mo = model(WW, op, d, s, we, exp_flw);
        exp_resw = mo[63:0];
        exp_flw  = mo[67:64];
        @(negedge clk);
        w_valid = 1'b0;
        checks++;
        if (w_res !== exp_resw || {w_zf, w_sf, w_cf, w_of} !== exp_flw) begin
            errors++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     tag, w_res, {w_zf, w_sf, w_cf, w_of}, exp_resw, exp_flw);
        end
    endtask

    task automatic fixed_w(logic [63:0] r, logic [3:0] fl, string tag);
        checks++;
        if (w_res !== r || {w_zf, w_sf, w_cf, w_of} !== fl) begin
            errors++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     tag, w_res, {w_zf, w_sf, w_cf, w_of}, r, fl);
        end
    endtask

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R12: reset state on both instances
        check8();
        fixed_w(64'h0, 4'b0000, "R12");
        rst_n = 1'b1;

        cyc = 0;
        for (int op = 0; op < 16; op++) begin
            for (int d = 0; d < 256; d++) begin
                for (int si = 0; si < 16; si++) begin
                    cyc++;
                    if (cyc % 13 == 0) issue8(1'b0, 4'(op), 8'(d + 3), 8'(si * 17), 1'b1);
                    issue8(1'b1, 4'(op), 8'(d), src_pick(si), (cyc % 7) != 0);
                end
            end
        end
        @(negedge clk);
        check8();
        n_valid = 1'b0;

        // full-width boundary cases; fixed values stated from R2-R4, R6
        wide(4'd1, 64'hffff_ffff_ffff_ffff, 64'h1, 1'b1, "R2 R4 wrap to zero");
        fixed_w(64'h0, 4'b1010, "R2 R3 R4 all-ones plus one");
        wide(4'd1, 64'h7fff_ffff_ffff_ffff, 64'h1, 1'b1, "R4 signed overflow");
        fixed_w(64'h8000_0000_0000_0000, 4'b0101, "R3 R4 max positive plus one");
        wide(4'd1, 64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, 1'b1, "R4 carry and overflow");
        fixed_w(64'h7fff_ffff_ffff_ffff, 4'b0011, "R4 min negative plus minus one");
        wide(4'd2, 64'h0, 64'h1, 1'b1, "R4 borrow");
        fixed_w(64'hffff_ffff_ffff_ffff, 4'b0110, "R4 zero minus one");
        wide(4'd4, 64'h5, 64'h0, 1'b1, "R5 carry kept by increment");
        wide(4'd5, 64'h8000_0000_0000_0000, 64'h0, 1'b1, "R5 decrement overflow");
        wide(4'd6, 64'h8000_0000_0000_0000, 64'h0, 1'b1, "R4 negate minimum");
        wide(4'd3, 64'h1_0000_0000, 64'h1_0000_0000, 1'b1, "R6 product too wide");
        wide(4'd3, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 1'b1, "R6 minus one squared");
        wide(4'd3, 64'hffff_ffff_8000_0000, 64'h1_0000_0000, 1'b1, "R6 exact minimum");
        wide(4'd7, 64'hc000_0000_0000_0001, 64'd63, 1'b1, "R7 arithmetic left");
        wide(4'd8, 64'hc000_0000_0000_0001, 64'd63, 1'b1, "R7 logical left");
        wide(4'd9, 64'h8000_0000_0000_0000, 64'd63, 1'b1, "R7 sign fill");
        wide(4'd10, 64'h8000_0000_0000_0000, 64'd63, 1'b1, "R7 zero fill");
        wide(4'd10, 64'h1234, 64'd64, 1'b1, "R8 count 64 wraps to zero");
        wide(4'd0, 64'h0, 64'hdead_beef, 1'b1, "R10 pass");
        wide(4'd1, 64'h7fff_ffff_ffff_ffff, 64'h1, 1'b0, "R10 masked add");
        wide(4'd14, 64'h0f0f, 64'h0, 1'b1, "R9 not");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule